// File: doc/BRIEF.md
# Framed Serial Word-Pair Transmitter

This block sends two 16-bit words as a single burst over a three-wire serial link: a bit clock, a frame marker and a data line. The timing is left-justified sample-pair framing. The frame marker is high for every bit of the first word and low for every bit of the second. The second word follows the first with no gap, and each word goes out most significant bit first. Data and frame marker change on the falling edge of the bit clock, so they are stable at the rising edge where a receiver samples them.

A clean single-cycle trigger pulse starts a burst. The block captures both parallel words on that trigger, so each trigger produces exactly one burst. A trigger that arrives while a burst is in flight is ignored. The bit clock is the system clock divided by an even parameter. A mode input selects between two clock behaviours. In one, the clock runs all the time. In the other, the clock is gated: it starts two full bit periods before the frame marker rises and stops low after the last bit.

Top module: `pair_frame_tx`

## Requirements
- R1: While reset is held and on the cycle after it is released, `ser_clk_o`, `frame_o`, `ser_data_o` and `busy_o` are all low.
- R2: A burst carries word A and then word B, 32 consecutive bit periods in total, each word most significant bit first, with no idle bit between the two words.
- R3: `frame_o` rises together with the first bit of word A. It stays high for exactly 16 bit periods and is low for the 16 bit periods of word B.
- R4: `ser_data_o` and `frame_o` change only on the system clock edge on which `ser_clk_o` falls.
- R5: One bit period lasts DIV system clock cycles, with `ser_clk_o` high for DIV/2 of them and low for DIV/2 of them.
- R6: With `gate_clk_i` = 1 (gated mode), `ser_clk_o` is low whenever `busy_o` is low. After a trigger, exactly two rising edges of `ser_clk_o` occur before the first rising edge at which `frame_o` is high.
- R7: With `gate_clk_i` = 0 (continuous mode), `ser_clk_o` keeps toggling with the period of R5 while the block is idle.
- R8: `busy_o` goes high on the cycle after a trigger and goes low on the falling clock edge that ends the last bit of word B. A trigger while `busy_o` is high starts no further burst.
- R9: `ser_data_o` and `frame_o` are low whenever `busy_o` is low. Changes on `word_a_i` and `word_b_i` after the trigger cycle do not alter the burst.
- R10: `gate_clk_i` is only changed while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Single-cycle start pulse |
| word_a_i | input | 16 | First word, sent while the frame marker is high |
| word_b_i | input | 16 | Second word, sent while the frame marker is low |
| gate_clk_i | input | 1 | 1 = gated bit clock, 0 = continuous bit clock |
| ser_clk_o | output | 1 | Serial bit clock |
| frame_o | output | 1 | Frame marker |
| ser_data_o | output | 1 | Serial data |
| busy_o | output | 1 | High while a burst is in progress |

## Verification
A wrong bit counter shows at the link within one bit period. A frame marker that drops early or late shows up as a misaligned high span at the rising edges. A stuck or missing shift shows up as a corrupted received word at the end of the 32nd bit. If the lead counter or the clock gating is in a wrong state, the count of clock rising edges before the marker changes, or the clock toggles while idle in gated mode, and this is visible within one bit period. A sequencer that fails to return to idle, or that restarts on a second trigger, shows as a busy flag that does not fall or as an extra burst with no matching expected pair, within one burst length.

// File: rtl/pair_frame_tx_pkg.sv
// Shared types for the framed word-pair transmitter.
package pair_frame_tx_pkg;

    // Sequencer phases: waiting, leading clock periods, shifting bits
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_SHIFT = 2'd2
    } tx_phase_e;

endpackage

// File: rtl/ptx_bitclk.sv
// Bit clock generator: divides the system clock by DIV (even, >= 2).
// Assumes run_i is held high for as long as the bit clock must toggle.
// When run_i is low the clock is held low and the phase counter is cleared,
// so the first toggle after run_i rises is a rising edge, DIV/2 cycles later.
module ptx_bitclk #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic fall_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          half_done;

    assign half_done = (cnt_q == CW'(HALF - 1));
    // Strobe for the system edge on which the bit clock goes from high to low
    assign fall_o    = run_i && half_done && sclk_o;

    // Half-period counter and bit clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q  <= '0;
            sclk_o <= 1'b0;
        end else if (half_done) begin
            cnt_q  <= '0;
            sclk_o <= ~sclk_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ptx_sequencer.sv
// Burst sequencer: captures two words on a trigger, waits LEAD falling edges
// of the bit clock, then shifts out 2*WORD_W bits MSB first, one per falling
// edge, with the frame marker high for the first WORD_W bits.
// Assumes fall_i is a one-cycle strobe coincident with the bit clock falling.
module ptx_sequencer
    import pair_frame_tx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LEAD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [WORD_W-1:0] word_a_i,
    input  logic [WORD_W-1:0] word_b_i,
    input  logic              fall_i,
    output logic              sd_o,
    output logic              fs_o,
    output logic              busy_o
);
    localparam int NBITS = 2 * WORD_W;
    localparam int BW    = $clog2(NBITS);
    localparam int LW    = $clog2(LEAD) + 1;

    tx_phase_e          phase_q;
    logic [NBITS-1:0]   shreg_q;
    logic [BW-1:0]      bit_q;
    logic [LW-1:0]      lead_q;

    assign busy_o = (phase_q != PH_IDLE);

    // Phase sequencing, shift register and serial outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            shreg_q <= '0;
            bit_q   <= '0;
            lead_q  <= '0;
            sd_o    <= 1'b0;
            fs_o    <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (trig_i) begin
                        phase_q <= PH_LEAD;
                        shreg_q <= {word_a_i, word_b_i};
                        lead_q  <= '0;
                    end
                end
                PH_LEAD: begin
                    if (fall_i) begin
                        if (lead_q == LW'(LEAD - 1)) begin
                            phase_q <= PH_SHIFT;
                            sd_o    <= shreg_q[NBITS-1];
                            shreg_q <= shreg_q << 1;
                            fs_o    <= 1'b1;
                            bit_q   <= '0;
                        end else begin
                            lead_q <= lead_q + 1'b1;
                        end
                    end
                end
                PH_SHIFT: begin
                    if (fall_i) begin
                        if (bit_q == BW'(NBITS - 1)) begin
                            phase_q <= PH_IDLE;
                            sd_o    <= 1'b0;
                            fs_o    <= 1'b0;
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            sd_o    <= shreg_q[NBITS-1];
                            shreg_q <= shreg_q << 1;
                            fs_o    <= ((int'(bit_q) + 1) < WORD_W);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R8
    retrig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHIFT && trig_i) |=> (phase_q != PH_LEAD));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && $past(phase_q) == PH_IDLE) |-> (!sd_o && !fs_o));

endmodule

// File: rtl/pair_frame_tx.sv
// Framed serial word-pair transmitter top. Joins the bit clock generator and
// the burst sequencer; the bit clock runs always, or only while busy when
// gate_clk_i is high. Assumes trig_i is a clean one-cycle pulse and
// gate_clk_i changes only while idle.
module pair_frame_tx #(
    parameter int WORD_W = 16,
    parameter int DIV    = 4,
    parameter int LEAD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [WORD_W-1:0] word_a_i,
    input  logic [WORD_W-1:0] word_b_i,
    input  logic              gate_clk_i,
    output logic              ser_clk_o,
    output logic              frame_o,
    output logic              ser_data_o,
    output logic              busy_o
);
    logic clk_run;
    logic fall_tick;

    // Bit clock enable: always in continuous mode, during a burst in gated mode
    assign clk_run = !gate_clk_i || busy_o;

    ptx_bitclk #(.DIV(DIV)) u_bitclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (clk_run),
        .sclk_o (ser_clk_o),
        .fall_o (fall_tick)
    );

    ptx_sequencer #(.WORD_W(WORD_W), .LEAD(LEAD)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .word_a_i (word_a_i),
        .word_b_i (word_b_i),
        .fall_i   (fall_tick),
        .sd_o     (ser_data_o),
        .fs_o     (frame_o),
        .busy_o   (busy_o)
    );

    // R4
    data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_data_o) |-> $fell(ser_clk_o));

    // R4
    frame_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_o) |-> $fell(ser_clk_o));

    // R6
    gated_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_clk_i && !busy_o && $past(gate_clk_i && !busy_o)) |-> !ser_clk_o);

    // R6
    lead_before_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !frame_o);

    // R9
    frame_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> busy_o);

endmodule

// File: tb/pair_frame_tx_test.sv
// Scoreboard bench: the driver task queues each expected pair, the monitor
// rebuilds frames from the link at bit clock rising edges and compares.
module pair_frame_tx_test;
    localparam int W   = 16;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic [W-1:0] wa = '0, wb = '0;
    logic gate = 1'b1;
    logic sclk, fs, sd, busy;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;

    logic [2*W:0] exp_q[$];
    int frames = 0;
    int pushed = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pair_frame_tx #(.WORD_W(W), .DIV(DIV), .LEAD(2)) uut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .word_a_i(wa), .word_b_i(wb),
        .gate_clk_i(gate), .ser_clk_o(sclk), .frame_o(fs), .ser_data_o(sd),
        .busy_o(busy)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor state
    logic prev_sclk = 1'b0, prev_busy = 1'b0, prev_gate = 1'b1;
    int idx = 0, pre_rises = 0;
    logic [2*W-1:0] rx = '0;
    bit fs_ok = 1, busy_ok = 1, got_frame = 0, have_last = 0;
    longint last_rise = 0;
    int rise_total = 0;

    // Monitor: samples the link away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!prev_sclk && sclk) begin
                rise_total++;
                if (have_last) chk(cyc - last_rise == DIV, "R5 rise period", cyc - last_rise, DIV);
                last_rise = cyc;
                have_last = 1;
                if (idx == 0 && !fs) begin
                    if (busy) pre_rises++;
                end else begin
                    rx = {rx[2*W-2:0], sd};
                    if (fs != (idx < W)) fs_ok = 0;
                    if (!busy) busy_ok = 0;
                    idx++;
                    if (idx == 2*W) begin
                        chk(exp_q.size() > 0, "R8 burst without trigger", 1, 0);
                        if (exp_q.size() > 0) begin
                            logic [2*W:0] e;
                            e = exp_q.pop_front();
                            chk(rx == e[2*W-1:0], "R2 received pair", rx, e[2*W-1:0]);
                            chk(fs_ok, "R3 frame marker span", 0, 1);
                            chk(busy_ok, "R8 busy during frame", 0, 1);
                            if (e[2*W]) chk(pre_rises == 2, "R6 lead rising edges", pre_rises, 2);
                        end
                        frames++;
                        got_frame = 1;
                        idx = 0; pre_rises = 0; fs_ok = 1; busy_ok = 1;
                    end
                end
            end
            if (prev_sclk && !sclk && have_last)
                chk(cyc - last_rise == DIV/2, "R5 high time", cyc - last_rise, DIV/2);
            if (prev_busy && !busy) begin
                chk(got_frame && idx == 0, "R8 busy falls after last bit", idx, 0);
                got_frame = 0;
            end
            if (!busy) begin
                chk(!sd && !fs, "R9 idle data and marker", {sd, fs}, 0);
                if (gate && prev_gate && !prev_busy) begin
                    chk(!sclk, "R6 gated idle clock", sclk, 0);
                    have_last = 0;
                end
            end
        end
        prev_sclk = sclk; prev_busy = busy; prev_gate = gate;
    end

    // Driver: one burst; optional retrigger while busy. R10: mode set while idle.
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic g, input bit retrig);
        while (busy) @(negedge clk);
        gate = g;
        repeat (3) @(negedge clk);
        wa = a; wb = b; trig = 1'b1;
        exp_q.push_back({g, a, b});
        pushed++;
        @(negedge clk);
        trig = 1'b0;
        chk(busy, "R8 busy after trigger", busy, 1);
        wa = ~a; wb = ~b;  // R9: late word changes must not matter
        if (retrig) begin
            repeat (20 * DIV) @(negedge clk);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (4 * DIV) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(!sclk && !fs && !sd && !busy, "R1 reset outputs", {sclk, fs, sd, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sclk && !fs && !sd && !busy, "R1 after release", {sclk, fs, sd, busy}, 0);

        send(16'hA5C3, 16'h0F0F, 1'b1, 0);
        send(16'hFFFF, 16'h0000, 1'b1, 0);
        send(16'h8001, 16'h7FFE, 1'b0, 0);
        begin
            int r0;
            r0 = rise_total;
            repeat (10 * DIV) @(negedge clk);
            chk(rise_total - r0 >= 9, "R7 continuous idle clock", rise_total - r0, 10);
        end
        send(16'h1234, 16'hFEDC, 1'b0, 1);
        send(16'hAAAA, 16'h5555, 1'b1, 1);
        send(16'h0001, 16'h8000, 1'b1, 0);
        repeat (60 * DIV) @(negedge clk);
        chk(exp_q.size() == 0, "R8 pending expected pairs", exp_q.size(), 0);
        chk(frames == pushed, "R8 one burst per trigger", frames, pushed);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule